// File: doc/BRIEF.md
# Serial ADC Device Interface

This block is the digital side of an 8-bit serial analog-to-digital converter that times its own conversions. A falling edge on the conversion strobe starts a conversion and latches the parallel code presented on `analog_code_i`. A conversion timer driven by the internal clock then runs for a fixed number of cycles. While the conversion is in progress the serial data pin is driven low. When the conversion ends, the most significant bit appears on the pin. The host then clocks out the byte with its own serial clock. After the last bit the pin returns to high impedance.

The strobe may idle either high or low. A second high-to-low pulse on the strobe, arriving shortly after the first, switches the conversion to an internal half-scale reference. That reference converts as the code 0x80. The host serial clock may idle low or high, and both produce the same bit order. The strobe and the serial clock are asynchronous to the internal clock, so both pass through synchronizers before any edge is detected. All timing below is counted in internal clock cycles, measured from the cycle in which a synchronized edge is acted upon.

Top module: `adc_serial_if`

## Requirements
- R1: After reset, `sdata_oe_o` is 0 and `sdata_o` is 0.
- R2: In the idle phase, a falling edge on `conv_strobe_i` starts a conversion and captures `analog_code_i` in that cycle. Later changes on `analog_code_i` do not alter the result. The strobe may idle high or low between conversions.
- R3: During a conversion, `sdata_oe_o` is 1 and `sdata_o` is 0.
- R4: A conversion lasts CONV_CYCLES clock cycles from the cycle in which its start edge is accepted. The first bit (bit 7) is on `sdata_o` in the very next cycle.
- R5: A second strobe falling edge selects the half-scale reference code 8'h80 in place of the captured code, provided it is accepted no more than PAIR_WIN cycles after the first one. A later second edge leaves the input code selected. Once the reference is chosen, further strobe edges do not undo the choice.
- R6: Edges on `sclk_i` during a conversion have no effect on the bits read out afterwards.
- R7: The byte is presented MSB first in straight binary. The pin advances to the next bit on each `sclk_i` falling edge that follows at least one rising edge of the readout. The host samples on rising edges.
- R8: With `sclk_i` idling low or idling high, the host reads the same 8-bit sequence.
- R9: After the eighth `sclk_i` rising edge, the last bit stays driven for TAIL_CYCLES cycles. After that, `sdata_oe_o` drops to 0. The default of 30 cycles at 200 MHz gives 150 ns, which lies inside the 100 to 500 ns window.
- R10: Strobe falling edges during readout or during the tail are ignored, and the byte being read is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_strobe_i | input | 1 | Conversion strobe; a falling edge starts a conversion, and a second one selects the reference |
| sclk_i | input | 1 | Host serial clock, asynchronous |
| analog_code_i | input | DATA_W | Parallel code standing in for the analog input |
| sdata_o | output | 1 | Serial data: low while busy, then the result, MSB first |
| sdata_oe_o | output | 1 | Output enable; 0 means high impedance |

## Verification
Two functions can fall in the same cycle: the pairing window closing, and a second strobe falling edge being accepted. Whether that edge counts as a channel select depends on a single cycle. The bench places the second falling edge exactly PAIR_WIN cycles after the first, and in a separate run one cycle later. Both strobe edges pass through the same synchronizer, so the gap between them is exact. A byte of 8'h80 is expected in the first run and the input code in the second. The exact busy-to-MSB transition and the exact release cycle of the output enable are also sampled at single-cycle resolution.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CONV  = 2'd1,
    PH_SHIFT = 2'd2,
    PH_TAIL  = 2'd3
  } phase_e;

  // width of a counter that must hold values 0..n
  function automatic int unsigned span_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  logic prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic q;
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= 1'b0;
          else        q <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= 1'b0;
          else        q <= g_stage[s-1].q;
        end
      end
    end
  endgenerate

  assign lvl_o = g_stage[STAGES-1].q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_o;
  end

  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CONV_CYCLES = 1500,
  parameter int PAIR_WIN    = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  output logic done_o,
  output logic window_o
);
  import adc_if_pkg::*;

  localparam int CW = span_width(CONV_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (start_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o   = run_i && (cnt_q == CW'(CONV_CYCLES - 1));
  assign window_o = run_i && (cnt_q < CW'(PAIR_WIN));

endmodule

// File: rtl/adc_shift_out.sv
module adc_shift_out #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         active_i,
  input  logic         rise_i,
  input  logic         fall_i,
  output logic         bit_o,
  output logic         step_o,
  output logic         last_o
);
  import adc_if_pkg::*;

  localparam int IW = span_width(W);

  logic [W-1:0]  sr_q;
  logic [IW-1:0] rcnt_q;

  // advance only after the host has sampled at least one bit
  assign step_o = active_i && fall_i && (rcnt_q != '0) && (rcnt_q < IW'(W));
  assign last_o = active_i && rise_i && (rcnt_q == IW'(W - 1));
  assign bit_o  = sr_q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      rcnt_q <= '0;
    end else if (load_i) begin
      sr_q   <= load_val_i;
      rcnt_q <= '0;
    end else begin
      if (active_i && rise_i && (rcnt_q < IW'(W))) rcnt_q <= rcnt_q + 1'b1;
      if (step_o) sr_q <= {sr_q[W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/adc_serial_if.sv
module adc_serial_if #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CONV_CYCLES = 1500,
  parameter int PAIR_WIN    = 200,
  parameter int TAIL_CYCLES = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_strobe_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] analog_code_i,
  output logic              sdata_o,
  output logic              sdata_oe_o
);
  import adc_if_pkg::*;

  localparam int TW = span_width(TAIL_CYCLES);

  function automatic logic [DATA_W-1:0] mid_code();
    logic [DATA_W-1:0] v;
    v = '0;
    v[DATA_W-1] = 1'b1;
    return v;
  endfunction

  phase_e            phase, phase_nxt;
  logic [DATA_W-1:0] cap_q;
  logic              use_mid;
  logic [TW-1:0]     tail_cnt;

  logic cs_lvl, cs_rise, cs_fall;
  logic sk_lvl, sk_rise, sk_fall;
  logic in_win, conv_done, shift_bit, shift_step, last_rise;

  // named events
  logic conv_start, pair_hit, tail_end;

  adc_edge_sync #(.STAGES(SYNC_STAGES)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .d_i(conv_strobe_i),
    .lvl_o(cs_lvl), .rise_o(cs_rise), .fall_o(cs_fall)
  );

  adc_edge_sync #(.STAGES(SYNC_STAGES)) u_sk_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sclk_i),
    .lvl_o(sk_lvl), .rise_o(sk_rise), .fall_o(sk_fall)
  );

  assign conv_start = (phase == PH_IDLE) && cs_fall;
  assign pair_hit   = (phase == PH_CONV) && cs_fall && in_win && !use_mid;
  assign tail_end   = (phase == PH_TAIL) && (tail_cnt == TW'(TAIL_CYCLES - 1));

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES), .PAIR_WIN(PAIR_WIN)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(conv_start),
    .run_i(phase == PH_CONV), .done_o(conv_done), .window_o(in_win)
  );

  adc_shift_out #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load_i(conv_done), .load_val_i(use_mid ? mid_code() : cap_q),
    .active_i(phase == PH_SHIFT), .rise_i(sk_rise), .fall_i(sk_fall),
    .bit_o(shift_bit), .step_o(shift_step), .last_o(last_rise)
  );

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_IDLE:  if (conv_start) phase_nxt = PH_CONV;
      PH_CONV:  if (conv_done)  phase_nxt = PH_SHIFT;
      PH_SHIFT: if (last_rise)  phase_nxt = PH_TAIL;
      PH_TAIL:  if (tail_end)   phase_nxt = PH_IDLE;
      default:  phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cap_q    <= '0;
      use_mid  <= 1'b0;
      tail_cnt <= '0;
    end else begin
      phase <= phase_nxt;
      if (conv_start) begin
        cap_q   <= analog_code_i;
        use_mid <= 1'b0;
      end else if (pair_hit) begin
        use_mid <= 1'b1;
      end
      if (last_rise)              tail_cnt <= '0;
      else if (phase == PH_TAIL)  tail_cnt <= tail_cnt + 1'b1;
    end
  end

  assign sdata_oe_o = (phase != PH_IDLE);
  assign sdata_o    = ((phase == PH_SHIFT) || (phase == PH_TAIL)) ? shift_bit : 1'b0;

endmodule

// File: rtl/adc_serial_if_chk.sv
module adc_serial_if_chk
  import adc_if_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input phase_e phase,
  input logic   sdata_o,
  input logic   sdata_oe_o,
  input logic   conv_start,
  input logic   conv_done,
  input logic   pair_hit,
  input logic   use_mid,
  input logic   last_rise,
  input logic   tail_end
);

  // R3
  busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (sdata_oe_o && !sdata_o));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV && !conv_done) |=> !sdata_o);

  // R5
  pair_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_hit |=> use_mid);

  // R5
  mid_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && use_mid) |=> (sdata_oe_o && sdata_o));

  // R9
  tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_rise |=> (sdata_oe_o && $stable(sdata_o)));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_end |=> !sdata_oe_o);

  // R10
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_start, conv_done, last_rise, tail_end}));

endmodule

bind adc_serial_if adc_serial_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase),
  .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o),
  .conv_start(conv_start), .conv_done(conv_done), .pair_hit(pair_hit),
  .use_mid(use_mid), .last_rise(last_rise), .tail_end(tail_end)
);

// File: tb/adc_serial_if_tb.sv
module adc_serial_if_tb;

  localparam int CONV = 1500;
  localparam int WIN  = 200;
  localparam int TAIL = 30;
  localparam int H    = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_strobe = 1'b0;
  logic       sclk = 1'b0;
  logic [7:0] code = 8'h00;
  logic       sdata, sdata_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];

  always #2.5 clk = ~clk;

  adc_serial_if #(
    .DATA_W(8), .SYNC_STAGES(2), .CONV_CYCLES(CONV),
    .PAIR_WIN(WIN), .TAIL_CYCLES(TAIL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .conv_strobe_i(conv_strobe), .sclk_i(sclk),
    .analog_code_i(code), .sdata_o(sdata), .sdata_oe_o(sdata_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares each read byte with the driver's prediction
  always @(negedge clk) begin
    if (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] a, e;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      check(a == e, "R2 R5 R7 byte", a, e);
    end
  end

  task automatic read_byte(input bit sck_hi, input bit glitch);
    logic [7:0] got;
    if (sck_hi) begin
      sclk = 1'b0;                    // R8: first fall must not advance
      repeat (H) @(negedge clk);
    end
    for (int i = 0; i < 8; i++) begin
      got[7-i] = sdata;
      if (glitch && i == 3) begin     // R10: strobe pulse during readout
        conv_strobe = 1'b1;
        repeat (3) @(negedge clk);
        conv_strobe = 1'b0;
        repeat (3) @(negedge clk);
      end
      sclk = 1'b1;
      if (i < 7) begin
        repeat (H) @(negedge clk);
        sclk = 1'b0;
        repeat (H) @(negedge clk);
      end
    end
    for (int n = 1; n <= TAIL + 3; n++) begin
      @(negedge clk);
      if (!sck_hi && n == H) sclk = 1'b0;
      if (n == TAIL + 2) check(sdata_oe == 1'b1, "R9 hold", sdata_oe, 1);
      if (n == TAIL + 3) check(sdata_oe == 1'b0, "R9 release", sdata_oe, 0);
    end
    act_q.push_back(got);
  endtask

  task automatic run_conv(input logic [7:0] smp, input int g2, input int g3,
                          input bit sck_hi, input bit cv_hi, input bit tog,
                          input bit glitch);
    logic [7:0] exp_b;
    exp_b = (g2 > 0 && g2 <= WIN) ? 8'h80 : smp;
    exp_q.push_back(exp_b);
    @(negedge clk);
    conv_strobe = 1'b1;
    sclk = sck_hi;
    code = smp;
    repeat (4) @(negedge clk);
    conv_strobe = 1'b0;
    for (int n = 1; n <= CONV + 3; n++) begin
      @(negedge clk);
      if (n == 5) code = ~smp;                        // R2: late change ignored
      if (g2 > 0 && n == g2 - 2) conv_strobe = 1'b1;  // R5 pairing pulse
      if (g2 > 0 && n == g2)     conv_strobe = 1'b0;
      if (g3 > 0 && n == g3 - 2) conv_strobe = 1'b1;
      if (g3 > 0 && n == g3)     conv_strobe = 1'b0;
      if (cv_hi && n == 400)     conv_strobe = 1'b1;
      if (tog && n >= 300 && n < 360 && (n % 10) == 0) sclk = ~sclk;  // R6
      if (n == 250) check(sdata_oe && !sdata, "R3 busy", {sdata_oe, sdata}, 2);
      if (n == CONV + 2) check(sdata_oe && !sdata, "R4 still busy", {sdata_oe, sdata}, 2);
      if (n == CONV + 3) check(sdata_oe && sdata == exp_b[7], "R4 msb", sdata, exp_b[7]);
    end
    read_byte(sck_hi, glitch);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sdata_oe == 1'b0 && sdata == 1'b0, "R1 reset", {sdata_oe, sdata}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sdata_oe == 1'b0, "R1 idle", sdata_oe, 0);
    run_conv(8'hA5, 0, 0, 1'b0, 1'b0, 1'b1, 1'b0);        // R2 R6 R7
    run_conv(8'h3C, 0, 0, 1'b1, 1'b1, 1'b0, 1'b0);        // R8 idle-high sclk, R2 strobe idle high
    run_conv(8'hA5, 0, 0, 1'b1, 1'b0, 1'b1, 1'b0);        // R8 same byte as first run
    run_conv(8'h11, 4, 0, 1'b0, 1'b0, 1'b0, 1'b0);        // R5 quick pair
    run_conv(8'h22, WIN, 0, 1'b0, 1'b0, 1'b0, 1'b0);      // R5 last window cycle
    run_conv(8'h5A, WIN + 1, 0, 1'b0, 1'b0, 1'b0, 1'b0);  // R5 one past window
    run_conv(8'h33, 4, 20, 1'b1, 1'b0, 1'b0, 1'b0);       // R5 third edge ignored
    run_conv(8'hC3, 0, 0, 1'b0, 1'b0, 1'b0, 1'b1);        // R10 strobe in readout
    run_conv(8'hFF, 0, 0, 1'b0, 1'b0, 1'b1, 1'b0);        // R7 all ones
    run_conv(8'h00, 0, 0, 1'b1, 1'b0, 1'b0, 1'b0);        // R7 all zeros
    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule